// File: doc/BRIEF.md
# Strided Two-Dimensional Memory Copy Engine

This block copies a region of memory from one place to another one byte at a time. It treats the region as a series of equal-sized chunks, which makes it suitable for rectangular copies such as blitting a window of a framebuffer. Inside a chunk, bytes move between consecutive addresses. Each new chunk begins a programmable distance (the stride) after the start of the previous chunk. The source and destination strides are set independently. The total length is programmed as the byte count minus one. The last chunk may therefore be shorter than the others.

Software sets up the transfer through a small register port. It writes the two base addresses, the chunk size, the two strides and the length. It then starts the copy with a two-step control sequence: first arm, then start. The engine reads each byte through a request channel and a response channel, and writes it back through a write channel. The request and write channels are valid/ready. While `valid` is high and `ready` is low, the engine holds the channel's address and data unchanged, so memory may stall it for any number of cycles. The read response is a single-cycle pulse with no back-pressure. It may arrive any number of cycles after the request is accepted. When the last byte is written, busy drops and a one-cycle completion pulse is raised.

Top module: `dma2d_copy`

## Requirements
- R1: Registers are selected by byte offset, and a write with `reg_addr[1:0]` not zero is ignored. The offsets are: control 0x00, source base 0x04, destination base 0x08, remaining count 0x0C, chunk size 0x10, source stride 0x14, destination stride 0x18. Every register except control reads back the value last written.
- R2: A control write stores `wdata[0]` as the arm flag. A control write of exactly 2 starts a transfer only if the arm flag was set beforehand. Reading control returns the arm flag in bit 0 and busy in bit 1, with all other bits zero.
- R3: A start write made while a transfer is busy is ignored. The running transfer still copies exactly its programmed number of bytes and raises exactly one completion pulse.
- R4: With length L and chunk size C, the transfer copies exactly L+1 bytes. Byte i is read from `src + (i/C)*sstride + (i%C)` and written to `dst + (i/C)*dstride + (i%C)`. No other address is written, and a final partial chunk stops at the exact byte count.
- R5: A chunk size of 0 behaves as a chunk size of 1.
- R6: Offset 0x0C reads the live remaining count. It equals L just after the start and reads all ones after completion, because the count passes below zero. Writes to it while busy are ignored.
- R7: `busy` falls in the same cycle that `done_irq` pulses high, and `done_irq` stays high for exactly one cycle.
- R8: Once `rd_req_valid` is high, it stays high with `rd_req_addr` unchanged until `rd_req_ready` is sampled high.
- R9: Once `wr_valid` is high, it stays high with `wr_addr` and `wr_data` unchanged until `wr_ready` is sampled high.
- R10: At most one byte is in flight, so `rd_req_valid` and `wr_valid` are never high together. While idle, both are low.
- R11: After reset, busy, the arm flag, both valids, `done_irq` and every register are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | W | Register write data |
| reg_rdata | output | W | Register read data (combinational on reg_addr) |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_req_addr | output | W | Read byte address |
| rd_resp_valid | input | 1 | Read data pulse |
| rd_resp_data | input | DW | Read data byte |
| wr_valid | output | 1 | Write valid |
| wr_ready | input | 1 | Write accepted |
| wr_addr | output | W | Write byte address |
| wr_data | output | DW | Write data byte |
| busy | output | 1 | Transfer in progress |
| done_irq | output | 1 | One-cycle completion pulse |

## Verification
On every cycle, the assertions check the following:
- the request and write channels hold their values while stalled;
- read requests and writes never overlap, and both stay quiet while idle;
- the completion pulse lasts one cycle and coincides with busy falling.

Other behaviour can only be shown by the bench's scenarios, run under randomly stalled memory:
- the address arithmetic across chunk sizes, strides and partial final chunks;
- the exact byte count;
- the arm-then-start rule and the ignored start and length writes while busy;
- the remaining-count readback.

// File: rtl/dma2d_pkg.sv
package dma2d_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RREQ  = 2'd1,
    ST_RWAIT = 2'd2,
    ST_WR    = 2'd3
  } mv_state_e;

  // Word index of each register (byte offset / 4)
  localparam logic [2:0] RI_CTRL  = 3'd0;
  localparam logic [2:0] RI_SRC   = 3'd1;
  localparam logic [2:0] RI_DST   = 3'd2;
  localparam logic [2:0] RI_REM   = 3'd3;
  localparam logic [2:0] RI_CHUNK = 3'd4;
  localparam logic [2:0] RI_SSTR  = 3'd5;
  localparam logic [2:0] RI_DSTR  = 3'd6;
endpackage

// File: rtl/dma2d_regs.sv
module dma2d_regs
  import dma2d_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [4:0]   addr,
  input  logic [W-1:0] wdata,
  input  logic         busy,
  input  logic [W-1:0] remain,
  output logic [W-1:0] rdata,
  output logic         start,
  output logic         len_wr,
  output logic [W-1:0] src_base,
  output logic [W-1:0] dst_base,
  output logic [W-1:0] chunk,
  output logic [W-1:0] sstr,
  output logic [W-1:0] dstr
);
  localparam logic [W-1:0] START_CODE = W'(2);

  logic       armed;
  logic [2:0] idx;
  logic       sel;

  assign idx = addr[4:2];
  assign sel = wr_en && (addr[1:0] == 2'b00);

  assign start  = sel && (idx == RI_CTRL) && (wdata == START_CODE) && armed && !busy;
  assign len_wr = sel && (idx == RI_REM) && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      armed    <= 1'b0;
      src_base <= '0;
      dst_base <= '0;
      chunk    <= '0;
      sstr     <= '0;
      dstr     <= '0;
    end else if (sel) begin
      case (idx)
        RI_CTRL:  armed    <= wdata[0];
        RI_SRC:   src_base <= wdata;
        RI_DST:   dst_base <= wdata;
        RI_CHUNK: chunk    <= wdata;
        RI_SSTR:  sstr     <= wdata;
        RI_DSTR:  dstr     <= wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    case (idx)
      RI_CTRL:  rdata = W'({busy, armed});
      RI_SRC:   rdata = src_base;
      RI_DST:   rdata = dst_base;
      RI_REM:   rdata = remain;
      RI_CHUNK: rdata = chunk;
      RI_SSTR:  rdata = sstr;
      RI_DSTR:  rdata = dstr;
      default:  rdata = '0;
    endcase
  end
endmodule

// File: rtl/dma2d_walker.sv
module dma2d_walker #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step,
  input  logic         len_wr,
  input  logic [W-1:0] len_val,
  input  logic [W-1:0] src_base,
  input  logic [W-1:0] dst_base,
  input  logic [W-1:0] chunk,
  input  logic [W-1:0] sstr,
  input  logic [W-1:0] dstr,
  output logic [W-1:0] src_addr,
  output logic [W-1:0] dst_addr,
  output logic [W-1:0] remain,
  output logic         last
);
  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] src_row, dst_row;
  logic [W-1:0] chunk_q, sstr_q, dstr_q;
  logic [W-1:0] cnt;
  logic         chunk_end;
  logic [W-1:0] src_next_row, dst_next_row;

  // Chunk size zero compares as "always at end", i.e. one byte per chunk
  assign chunk_end    = (cnt + ONE) >= chunk_q;
  assign src_next_row = src_row + sstr_q;
  assign dst_next_row = dst_row + dstr_q;
  assign last         = (remain == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_row  <= '0;
      dst_row  <= '0;
      src_addr <= '0;
      dst_addr <= '0;
      chunk_q  <= '0;
      sstr_q   <= '0;
      dstr_q   <= '0;
      cnt      <= '0;
    end else if (load) begin
      src_row  <= src_base;
      dst_row  <= dst_base;
      src_addr <= src_base;
      dst_addr <= dst_base;
      chunk_q  <= chunk;
      sstr_q   <= sstr;
      dstr_q   <= dstr;
      cnt      <= '0;
    end else if (step) begin
      if (chunk_end) begin
        src_row  <= src_next_row;
        dst_row  <= dst_next_row;
        src_addr <= src_next_row;
        dst_addr <= dst_next_row;
        cnt      <= '0;
      end else begin
        src_addr <= src_addr + ONE;
        dst_addr <= dst_addr + ONE;
        cnt      <= cnt + ONE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      remain <= '0;
    else if (len_wr) remain <= len_val;
    else if (step)   remain <= remain - ONE;
  end
endmodule

// File: rtl/dma2d_mover.sv
module dma2d_mover
  import dma2d_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          last,
  input  logic          rd_req_ready,
  input  logic          rd_resp_valid,
  input  logic [DW-1:0] rd_resp_data,
  input  logic          wr_ready,
  output logic          rd_req_valid,
  output logic          wr_valid,
  output logic [DW-1:0] wr_data,
  output logic          step,
  output logic          busy,
  output logic          done_irq
);
  mv_state_e     state_q, state_d;
  logic [DW-1:0] data_q;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:  if (start)         state_d = ST_RREQ;
      ST_RREQ:  if (rd_req_ready)  state_d = ST_RWAIT;
      ST_RWAIT: if (rd_resp_valid) state_d = ST_WR;
      ST_WR:    if (wr_ready)      state_d = last ? ST_IDLE : ST_RREQ;
      default:                     state_d = ST_IDLE;
    endcase
  end

  assign rd_req_valid = (state_q == ST_RREQ);
  assign wr_valid     = (state_q == ST_WR);
  assign busy         = (state_q != ST_IDLE);
  assign step         = wr_valid && wr_ready;
  assign wr_data      = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      data_q   <= '0;
      done_irq <= 1'b0;
    end else begin
      state_q  <= state_d;
      done_irq <= step && last;
      if (state_q == ST_RWAIT && rd_resp_valid) data_q <= rd_resp_data;
    end
  end
endmodule

// File: rtl/dma2d_copy.sv
module dma2d_copy #(
  parameter int W  = 32,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr_en,
  input  logic [4:0]    reg_addr,
  input  logic [W-1:0]  reg_wdata,
  output logic [W-1:0]  reg_rdata,
  output logic          rd_req_valid,
  input  logic          rd_req_ready,
  output logic [W-1:0]  rd_req_addr,
  input  logic          rd_resp_valid,
  input  logic [DW-1:0] rd_resp_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [W-1:0]  wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          busy,
  output logic          done_irq
);
  logic         start, len_wr, step, last;
  logic [W-1:0] src_base, dst_base, chunk, sstr, dstr, remain;

  dma2d_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .remain(remain), .rdata(reg_rdata),
    .start(start), .len_wr(len_wr), .src_base(src_base), .dst_base(dst_base),
    .chunk(chunk), .sstr(sstr), .dstr(dstr)
  );

  dma2d_walker #(.W(W)) u_walker (
    .clk(clk), .rst_n(rst_n), .load(start), .step(step), .len_wr(len_wr),
    .len_val(reg_wdata), .src_base(src_base), .dst_base(dst_base),
    .chunk(chunk), .sstr(sstr), .dstr(dstr), .src_addr(rd_req_addr),
    .dst_addr(wr_addr), .remain(remain), .last(last)
  );

  dma2d_mover #(.DW(DW)) u_mover (
    .clk(clk), .rst_n(rst_n), .start(start), .last(last),
    .rd_req_ready(rd_req_ready), .rd_resp_valid(rd_resp_valid),
    .rd_resp_data(rd_resp_data), .wr_ready(wr_ready),
    .rd_req_valid(rd_req_valid), .wr_valid(wr_valid), .wr_data(wr_data),
    .step(step), .busy(busy), .done_irq(done_irq)
  );
endmodule

// File: rtl/dma2d_checker.sv
module dma2d_checker #(
  parameter int W  = 32,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_req_valid,
  input logic          rd_req_ready,
  input logic [W-1:0]  rd_req_addr,
  input logic          wr_valid,
  input logic          wr_ready,
  input logic [W-1:0]  wr_addr,
  input logic [DW-1:0] wr_data,
  input logic          busy,
  input logic          done_irq
);
  a_r8_rd_hold: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));

  a_r9_wr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |=> !done_irq);

  a_r7_fall_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done_irq);

  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_irq |-> !busy);

  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_req_valid && wr_valid));

  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !rd_req_valid && !wr_valid);
endmodule

bind dma2d_copy dma2d_checker #(.W(W), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr),
  .wr_data(wr_data), .busy(busy), .done_irq(done_irq)
);

// File: tb/test_dma2d_copy.sv
module test_dma2d_copy;
  localparam int W  = 32;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr_en = 1'b0;
  logic [4:0]    reg_addr = '0;
  logic [W-1:0]  reg_wdata = '0;
  logic [W-1:0]  reg_rdata;
  logic          rd_req_valid, rd_req_ready = 1'b0;
  logic [W-1:0]  rd_req_addr;
  logic          rd_resp_valid = 1'b0;
  logic [DW-1:0] rd_resp_data = '0;
  logic          wr_valid, wr_ready = 1'b0;
  logic [W-1:0]  wr_addr;
  logic [DW-1:0] wr_data;
  logic          busy, done_irq;

  int checks = 0, failures = 0;
  int wr_cnt = 0, irq_cnt = 0;
  bit finished = 0;

  logic [7:0] mem     [0:1023];
  logic [7:0] ref_mem [0:1023];

  always #4 clk = ~clk;

  dma2d_copy #(.W(W), .DW(DW)) i_dma2d_copy (.*);

  // Memory model: acts at falling edges only
  initial begin : mem_model
    logic       hs_rd, hs_wr;
    logic [9:0] ra, wa;
    logic [7:0] wd;
    logic [7:0] lfsr;
    hs_rd = 0; hs_wr = 0; ra = 0; wa = 0; wd = 0; lfsr = 8'h5B;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        hs_rd = 0; hs_wr = 0;
        rd_req_ready = 0; wr_ready = 0; rd_resp_valid = 0;
      end else begin
        if (hs_wr) begin mem[wa] = wd; wr_cnt++; end
        rd_resp_valid = hs_rd;
        if (hs_rd) rd_resp_data = mem[ra];
        if (done_irq) irq_cnt++;
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        rd_req_ready = lfsr[0] | lfsr[3];
        wr_ready     = lfsr[1] | lfsr[5];
        hs_rd = rd_req_valid && rd_req_ready; ra = rd_req_addr[9:0];
        hs_wr = wr_valid && wr_ready; wa = wr_addr[9:0]; wd = wr_data;
      end
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic reg_write(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic reg_read(input logic [4:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 4000) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
  endtask

  // mode 0: plain; 1: start and length writes while busy
  task automatic run_xfer(input int c, input int len, input int ss, input int ds,
                          input int sb, input int db, input int mode);
    int cs;
    logic [31:0] v;
    cs = (c == 0) ? 1 : c;
    for (int i = 0; i < 1024; i++) begin
      mem[i] = (i < 512) ? 8'((i * 7 + len * 3 + c) ^ 8'h5A) : 8'(i ^ 8'h3C);
      ref_mem[i] = mem[i];
    end
    for (int i = 0; i < len; i++)
      ref_mem[db + (i / cs) * ds + (i % cs)] = ref_mem[sb + (i / cs) * ss + (i % cs)];
    reg_write(5'h04, 32'(sb));
    reg_write(5'h08, 32'(db));
    reg_write(5'h0C, 32'(len - 1));
    reg_write(5'h10, 32'(c));
    reg_write(5'h14, 32'(ss));
    reg_write(5'h18, 32'(ds));
    reg_write(5'h00, 32'h1);
    wr_cnt = 0; irq_cnt = 0;
    reg_write(5'h00, 32'h2);
    check(busy === 1'b1, "R2", "busy after start", 32'(busy), 1);
    if (mode == 1) begin
      reg_read(5'h0C, v);
      check(v == 32'(len - 1) || v == 32'(len - 2), "R6", "remaining early", v, 32'(len - 1));
      reg_write(5'h0C, 32'd60);
      reg_write(5'h00, 32'h1);
      reg_write(5'h00, 32'h2);
    end
    wait_idle();
    check(busy === 1'b0, "R7", "busy cleared", 32'(busy), 0);
    check(wr_cnt == len, (mode == 1) ? "R3" : "R4", "bytes written", wr_cnt, len);
    check(irq_cnt == 1, "R7", "completion pulses", irq_cnt, 1);
    begin
      int mism = 0;
      for (int i = 0; i < 1024; i++) if (mem[i] !== ref_mem[i]) mism++;
      check(mism == 0, (c == 0) ? "R5" : "R4", "memory image mismatches", mism, 0);
    end
    reg_read(5'h0C, v);
    check(v == 32'hFFFF_FFFF, "R6", "remaining after done", v, 32'hFFFF_FFFF);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    check(busy === 0 && done_irq === 0, "R11", "busy/done after reset", {busy, done_irq}, 0);
    check(rd_req_valid === 0 && wr_valid === 0, "R11", "valids after reset",
          {rd_req_valid, wr_valid}, 0);
    reg_read(5'h00, v); check(v == 0, "R11", "control after reset", v, 0);
    reg_read(5'h0C, v); check(v == 0, "R11", "remaining after reset", v, 0);

    // R1 readback of each register
    for (int r = 1; r <= 6; r++) begin
      reg_write(5'(r * 4), 32'h1000 + 32'(r * 17));
      reg_read(5'(r * 4), v);
      check(v == 32'h1000 + 32'(r * 17), "R1", "register readback", v, 32'h1000 + 32'(r * 17));
    end
    reg_write(5'h05, 32'hDEAD);
    reg_read(5'h04, v);
    check(v == 32'h1011, "R1", "misaligned write ignored", v, 32'h1011);

    // R2 arm rules
    reg_write(5'h00, 32'h0);
    reg_write(5'h00, 32'h2);
    check(busy === 0, "R2", "start without arm ignored", 32'(busy), 0);
    reg_write(5'h00, 32'h1);
    reg_read(5'h00, v); check(v == 32'h1, "R2", "armed flag read", v, 1);
    reg_write(5'h00, 32'h3);
    check(busy === 0, "R2", "value 3 does not start", 32'(busy), 0);
    reg_read(5'h00, v); check(v == 32'h1, "R2", "arm kept by bit0", v, 1);
    reg_write(5'h00, 32'h0);

    // Directed partial chunk case and busy interference
    run_xfer(3, 8, 10, 6, 16, 600, 0);
    run_xfer(4, 11, 9, 5, 40, 520, 1);
    run_xfer(0, 5, 3, 2, 8, 700, 1);

    // Sweep
    for (int c = 0; c <= 4; c++)
      for (int len = 1; len <= 10; len++)
        for (int s = 0; s < 2; s++)
          for (int d = 0; d < 2; d++)
            run_xfer(c, len, (s == 0) ? ((c == 0) ? 1 : c) : 6, (d == 0) ? 3 : 7,
                     c * 5 + len, 512 + len * 9, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule